// File: doc/BRIEF.md
# Write-Protected System Clock Control Register

This block holds the 8-bit control word that steers a small microcontroller clock generator. Software reaches it over a simple register bus with address, write data, write strobe and read strobe. A write lands only while a separate unlock flag, driven from outside the block, is high. The stored word is decoded into control lines for the rest of the clock generator:

- clock-output pin function
- peripheral clock gating during wait
- sub-oscillator drive strength
- sub-oscillator pin enable
- main oscillator stop
- divide-by-8 select
- CPU clock source select

Hardware also corrects the word on its own. Entry into stop mode raises the sub-oscillator drive and, from the faster run modes, the divide-by-8 bit. A disabled sub-oscillator pin keeps the drive bit high. A stopped main clock with the ring oscillator off pins divide-by-8 high, and the block reports that an external drive-strength bit is held high. A request to stop the main oscillator is refused while the CPU still depends on it. A refused request raises a sticky error flag, which software clears by reading the register.

Top module: `sysclk_ctl_reg`

## Requirements
- R1: After reset the register reads 8'h48, which means bit 6 = 1, bit 3 = 1 and all other bits 0, and `seq_err` is 0.
- R2: A write changes the register only when `bus_we` is 1, `bus_addr` equals `REG_ADDR` (default 6) and `wr_unlock` is 1. Any other write leaves every register bit unchanged.
- R3: The bit fields decode as follows:
  - `clk_out_sel` = bits 1:0 (00 I/O port, 01 fC, 10 f8, 11 f32)
  - `wait_gate` = bit 2
  - `sub_drive_hi` = bit 3
  - `sub_pin_en` = bit 4
  - `main_osc_stop` = bit 5
  - `div8_sel` = bit 6
  - `sub_clk_sel` = bit 7 (1 = sub clock, 0 = main/PLL/ring clock)
- R4: Whenever bit 4 is 0, bit 3 is 1.
- R5: A cycle with `stop_enter` = 1 sets bit 3. It also sets bit 6 when `run_mode` is high-speed (0), middle-speed (1), ring (4) or ring low-power (5). Low-speed (2) and low-power (3) leave bit 6 as it was.
- R6: While `ring_osc_en` is 0 and bit 5 is 1, bit 6 reads 1 and `drive_hold` is 1. Otherwise `drive_hold` is 0.
- R7: An accepted write that would take bit 5 from 0 to 1 while the current bit 7 and `ring_osc_en` are both 0 leaves bit 5 at 0 and sets `seq_err`. The other bits of that write still land.
- R8: `seq_err` stays 1 until a cycle with `bus_re` = 1 at `REG_ADDR` clears it. A new refusal in that same cycle keeps it at 1.
- R9: `bus_rdata` returns the effective register value, forced bits included, whenever `bus_addr` equals `REG_ADDR`, whatever the value of `wr_unlock`. At any other address it returns 0.
- R10: When a forced-bit rule and an accepted write touch the same bit in the same cycle, the forced value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe (clears the error flag) |
| bus_rdata | output | 8 | Read data |
| wr_unlock | input | 1 | Write protect release |
| stop_enter | input | 1 | One-cycle pulse on stop-mode entry |
| run_mode | input | 3 | Current operating mode code |
| ring_osc_en | input | 1 | Ring oscillator selected/enabled |
| clk_out_sel | output | 2 | Clock-output pin function |
| wait_gate | output | 1 | Stop peripheral clock in wait |
| sub_drive_hi | output | 1 | Sub-oscillator high drive |
| sub_pin_en | output | 1 | Sub-oscillator pins enabled |
| main_osc_stop | output | 1 | Main oscillator stopped |
| div8_sel | output | 1 | Divide-by-8 mode |
| sub_clk_sel | output | 1 | CPU runs from sub clock |
| drive_hold | output | 1 | External drive-strength bit held high |
| seq_err | output | 1 | Sticky refused-stop flag |

## Verification
The hardest state to reach is the cycle where several rules meet. In that cycle a refused main-stop write coincides with a clearing read, a stop-mode pulse, or a write that tries to clear bits the hardware is forcing. The bench builds these collisions on purpose: it first sets up the sub-clock or ring-oscillator preconditions, then drives all the competing strobes in one cycle. After the directed cases, a long run of random bus traffic with random mode and stop inputs is checked on every cycle against a behavioural model.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
    localparam int CTL_W = 8;

    // bit positions inside the control word
    localparam int B_WAIT  = 2;
    localparam int B_DRV   = 3;
    localparam int B_PIN   = 4;
    localparam int B_MSTOP = 5;
    localparam int B_DIV8  = 6;
    localparam int B_SUB   = 7;

    localparam logic [CTL_W-1:0] CTL_RST = 8'h48;

    // operating mode codes
    localparam logic [2:0] M_HIGH  = 3'd0;
    localparam logic [2:0] M_MID   = 3'd1;
    localparam logic [2:0] M_LOW   = 3'd2;
    localparam logic [2:0] M_LOWPW = 3'd3;
    localparam logic [2:0] M_RING  = 3'd4;
    localparam logic [2:0] M_RINGL = 3'd5;

    typedef struct packed {
        logic [CTL_W-1:0] ctl;
        logic             err;
    } ctl_state_t;
endpackage

// File: rtl/sysclk_wr_gate.sv
// Screens an accepted write: refuses a 0->1 main-stop request while the CPU
// still runs from the main clock.
module sysclk_wr_gate
    import sysclk_pkg::*;
(
    input  logic [CTL_W-1:0] cur_q,
    input  logic [CTL_W-1:0] wdata,
    input  logic             ring_osc_en,
    output logic [CTL_W-1:0] wval,
    output logic             refused
);
    logic off_main;

    always_comb begin
        off_main = cur_q[B_SUB] | ring_osc_en;
        refused  = wdata[B_MSTOP] & ~cur_q[B_MSTOP] & ~off_main;
        wval     = wdata;
        if (refused) begin
            wval[B_MSTOP] = 1'b0;
        end
    end
endmodule

// File: rtl/sysclk_decode.sv
// Splits the effective control word into control lines.
module sysclk_decode
    import sysclk_pkg::*;
(
    input  logic [CTL_W-1:0] eff,
    output logic [1:0]       clk_out_sel,
    output logic             wait_gate,
    output logic             sub_drive_hi,
    output logic             sub_pin_en,
    output logic             main_osc_stop,
    output logic             div8_sel,
    output logic             sub_clk_sel
);
    always_comb begin
        clk_out_sel   = eff[1:0];
        wait_gate     = eff[B_WAIT];
        sub_drive_hi  = eff[B_DRV];
        sub_pin_en    = eff[B_PIN];
        main_osc_stop = eff[B_MSTOP];
        div8_sel      = eff[B_DIV8];
        sub_clk_sel   = eff[B_SUB];
    end
endmodule

// File: rtl/sysclk_ctl_reg.sv
module sysclk_ctl_reg
    import sysclk_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [7:0]        bus_rdata,
    input  logic              wr_unlock,
    input  logic              stop_enter,
    input  logic [2:0]        run_mode,
    input  logic              ring_osc_en,
    output logic [1:0]        clk_out_sel,
    output logic              wait_gate,
    output logic              sub_drive_hi,
    output logic              sub_pin_en,
    output logic              main_osc_stop,
    output logic              div8_sel,
    output logic              sub_clk_sel,
    output logic              drive_hold,
    output logic              seq_err
);
    ctl_state_t       st_q, st_d;
    logic             hit, wr_ok, rd_hit, refused, fast_mode, hold_cond;
    logic [CTL_W-1:0] wval, eff;

    sysclk_wr_gate u_gate (
        .cur_q       (st_q.ctl),
        .wdata       (bus_wdata),
        .ring_osc_en (ring_osc_en),
        .wval        (wval),
        .refused     (refused)
    );

    always_comb begin
        hit       = (bus_addr == REG_ADDR);
        wr_ok     = bus_we & hit & wr_unlock;
        rd_hit    = bus_re & hit;
        fast_mode = (run_mode == M_HIGH) || (run_mode == M_MID) ||
                    (run_mode == M_RING) || (run_mode == M_RINGL);
        hold_cond = ~ring_osc_en & st_q.ctl[B_MSTOP];

        // effective value seen by readers and decoders
        eff = st_q.ctl;
        if (hold_cond) begin
            eff[B_DIV8] = 1'b1;
        end

        // next state: bus write first, forced rules applied on top
        st_d = st_q;
        if (wr_ok) begin
            st_d.ctl = wval;
        end
        if (rd_hit) begin
            st_d.err = 1'b0;
        end
        if (wr_ok && refused) begin
            st_d.err = 1'b1;
        end
        if (stop_enter) begin
            st_d.ctl[B_DRV] = 1'b1;
            if (fast_mode) begin
                st_d.ctl[B_DIV8] = 1'b1;
            end
        end
        if (!st_d.ctl[B_PIN]) begin
            st_d.ctl[B_DRV] = 1'b1;
        end
        if (!ring_osc_en && st_d.ctl[B_MSTOP]) begin
            st_d.ctl[B_DIV8] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ctl <= CTL_RST;
            st_q.err <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    sysclk_decode u_dec (
        .eff           (eff),
        .clk_out_sel   (clk_out_sel),
        .wait_gate     (wait_gate),
        .sub_drive_hi  (sub_drive_hi),
        .sub_pin_en    (sub_pin_en),
        .main_osc_stop (main_osc_stop),
        .div8_sel      (div8_sel),
        .sub_clk_sel   (sub_clk_sel)
    );

    assign bus_rdata  = hit ? eff : 8'h00;
    assign drive_hold = hold_cond;
    assign seq_err    = st_q.err;

    // R2: a refused or absent write leaves the word alone when no rule fires
    p_locked_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ok && !stop_enter && (ring_osc_en || !st_q.ctl[B_MSTOP]))
        |=> $stable(st_q.ctl));

    // R4: pin disabled implies high drive
    p_drive_forced_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sub_pin_en |-> sub_drive_hi);

    // R5: stop entry raises drive, and divide-by-8 from the fast modes
    p_stop_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_enter |=> sub_drive_hi);
    p_stop_div8_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_enter && fast_mode) |=> div8_sel);

    // R6: stopped main with ring off pins divide-by-8
    p_hold_div8_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!ring_osc_en && main_osc_stop) |-> (div8_sel && drive_hold));

    // R7: main oscillator only stops once the CPU is off the main clock
    p_mstop_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_osc_stop) |-> $past(sub_clk_sel || ring_osc_en));

    // R8: error flag is sticky until read
    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_err && !rd_hit) |=> seq_err);
endmodule

// File: tb/tb_sysclk_ctl_reg.sv
module tb_sysclk_ctl_reg;
    localparam int PERIOD = 10;
    localparam int AW = 4;

    logic clk = 0, rst_n = 0;
    logic [AW-1:0] bus_addr = 6;
    logic [7:0] bus_wdata = 0, bus_rdata;
    logic bus_we = 0, bus_re = 0, wr_unlock = 0, stop_enter = 0, ring_osc_en = 0;
    logic [2:0] run_mode = 0;
    logic [1:0] clk_out_sel;
    logic wait_gate, sub_drive_hi, sub_pin_en, main_osc_stop, div8_sel, sub_clk_sel;
    logic drive_hold, seq_err;

    int n_cmp = 0, n_bad = 0;
    int m_reg = 8'h48;
    int m_err = 0;

    always #(PERIOD/2) clk = ~clk;

    sysclk_ctl_reg #(.ADDR_W(AW), .REG_ADDR(6)) dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
        .wr_unlock(wr_unlock), .stop_enter(stop_enter), .run_mode(run_mode),
        .ring_osc_en(ring_osc_en), .clk_out_sel(clk_out_sel), .wait_gate(wait_gate),
        .sub_drive_hi(sub_drive_hi), .sub_pin_en(sub_pin_en),
        .main_osc_stop(main_osc_stop), .div8_sel(div8_sel), .sub_clk_sel(sub_clk_sel),
        .drive_hold(drive_hold), .seq_err(seq_err)
    );

    // behavioural reference, updated at every rising edge
    always @(posedge clk) begin
        int nx, ne, w;
        bit blocked;
        if (!rst_n) begin
            m_reg = 8'h48;
            m_err = 0;
        end else begin
            nx = m_reg; ne = m_err; blocked = 0;
            if (bus_we && bus_addr == 6 && wr_unlock) begin
                w = bus_wdata;
                if (w[5] && !m_reg[5] && !m_reg[7] && !ring_osc_en) begin
                    w[5] = 0;
                    blocked = 1;
                end
                nx = w;
            end
            if (bus_re && bus_addr == 6) ne = 0;
            if (blocked) ne = 1;
            if (stop_enter) begin
                nx[3] = 1;
                if (run_mode inside {0, 1, 4, 5}) nx[6] = 1;
            end
            if (!nx[4]) nx[3] = 1;
            if (!ring_osc_en && nx[5]) nx[6] = 1;
            m_reg = nx & 8'hff;
            m_err = ne;
        end
    end

    function automatic int model_eff();
        int e = m_reg;
        if (!ring_osc_en && m_reg[5]) e[6] = 1;
        return e & 8'hff;
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // full comparison of every output against the model
    task automatic compare_all();
        int e = model_eff();
        chk("R9 rdata", int'(bus_rdata), (bus_addr == 6) ? e : 0);
        chk("R3 decode", int'({sub_clk_sel, div8_sel, main_osc_stop, sub_pin_en,
                               sub_drive_hi, wait_gate, clk_out_sel}), e);
        chk("R6 drive_hold", int'(drive_hold), (!ring_osc_en && m_reg[5]) ? 1 : 0);
        chk("R8 seq_err", int'(seq_err), m_err);
    endtask

    // one bus cycle: drive at negedge, compare at the following negedge
    task automatic cyc(logic we, logic re, logic unl, logic [7:0] wd,
                       logic stp = 0, logic [2:0] md = 0, logic ring = 0,
                       logic [AW-1:0] ad = 6);
        bus_we = we; bus_re = re; wr_unlock = unl; bus_wdata = wd;
        stop_enter = stp; run_mode = md; ring_osc_en = ring; bus_addr = ad;
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(logic ring = 0);
        cyc(0, 0, 0, 8'h00, 0, 0, ring);
    endtask

    initial begin
        #(PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset value
        chk("R1 reset", int'(bus_rdata), 8'h48);
        chk("R1 err", int'(seq_err), 0);

        // R2: locked write and wrong-address write ignored
        cyc(1, 0, 0, 8'h17);
        chk("R2 locked", int'(bus_rdata), 8'h48);
        cyc(1, 0, 1, 8'h17, 0, 0, 0, 4'd5);
        idle();
        chk("R2 addr", int'(bus_rdata), 8'h48);

        // R3: clock-output patterns and field positions
        for (int k = 0; k < 4; k++) begin
            cyc(1, 0, 1, 8'h14 | k[7:0]);
            chk("R3 clk_out_sel", int'(clk_out_sel), k);
        end
        cyc(1, 0, 1, 8'h94);
        chk("R3 sub_clk_sel", int'(sub_clk_sel), 1);
        chk("R3 wait_gate", int'(wait_gate), 1);

        // R4: pin disabled forces drive high; enabled allows low
        cyc(1, 0, 1, 8'h00);
        chk("R4 forced", int'(sub_drive_hi), 1);
        cyc(1, 0, 1, 8'h10);
        chk("R4 free", int'(sub_drive_hi), 0);

        // R5: stop entry from low-speed keeps div8, from high sets it
        cyc(1, 0, 1, 8'h10);
        cyc(0, 0, 0, 8'h00, 1, 3'd2);
        chk("R5 drive", int'(sub_drive_hi), 1);
        chk("R5 low-speed div8", int'(div8_sel), 0);
        cyc(0, 0, 0, 8'h00, 1, 3'd4);
        chk("R5 ring div8", int'(div8_sel), 1);

        // R10: write clearing bits 3 and 6 during stop entry loses
        cyc(1, 0, 1, 8'h10, 1, 3'd0);
        chk("R10 priority", int'(bus_rdata), 8'h58);

        // R7: illegal main stop request refused, other bits land
        cyc(1, 0, 1, 8'h31);
        chk("R7 refused", int'(main_osc_stop), 0);
        chk("R7 others", int'(clk_out_sel), 1);
        chk("R7 err", int'(seq_err), 1);

        // R9: read works while locked; R8: read clears error
        cyc(0, 1, 0, 8'h00);
        chk("R8 cleared", int'(seq_err), 0);

        // R8: refusal together with a read keeps the flag set
        cyc(1, 1, 1, 8'h30);
        chk("R8 set wins", int'(seq_err), 1);
        cyc(0, 1, 0, 8'h00);

        // R7: legal stop via sub clock; R6 hold
        cyc(1, 0, 1, 8'h90);
        cyc(1, 0, 1, 8'hB0);
        chk("R7 legal", int'(main_osc_stop), 1);
        chk("R6 div8", int'(div8_sel), 1);
        chk("R6 hold", int'(drive_hold), 1);
        // R10: write trying to clear div8 while held
        cyc(1, 0, 1, 8'hB0);
        chk("R10 hold wins", int'(div8_sel), 1);
        cyc(0, 0, 0, 8'h00, 0, 0, 1);
        chk("R6 ring on", int'(drive_hold), 0);

        // R7: legal stop via ring oscillator
        cyc(1, 0, 1, 8'h10, 0, 0, 1);
        cyc(1, 0, 1, 8'h30, 0, 0, 1);
        chk("R7 ring legal", int'(main_osc_stop), 1);
        chk("R6 ring div8 free", int'(div8_sel), 0);

        // random traffic compared each cycle
        for (int i = 0; i < 3000; i++) begin
            cyc($urandom_range(0, 2) == 0, $urandom_range(0, 5) == 0,
                $urandom_range(0, 3) != 0, 8'($urandom),
                $urandom_range(0, 7) == 0, 3'($urandom),
                $urandom_range(0, 1) == 1,
                ($urandom_range(0, 5) == 0) ? AW'($urandom) : AW'(6));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule